// File: doc/BRIEF.md
# Nine-Bit Link Receive Deframer

The deframer sits between a receiver that delivers 9-bit characters from a serial link and a memory write port. Before a message arrives, the controller loads a receive descriptor. The descriptor holds an 18-bit byte address and a capacity in 16-bit words. The block then strips the framing and pairs the incoming bytes into words. It writes each word at the current address and moves the address on by two after every word.

A parameter selects one of two framing modes. In the framed mode, every message starts with two all-zero characters that serve as a header. The message ends on the character that carries the ninth bit. In the headerless mode, data starts with the first character. The message ends on the byte value 0x04, and that byte is stored like any other data byte.

When a message finishes, the block pulses a completion strobe. The strobe carries the number of words written and a flag that is set when the final word holds only one byte. A write that the memory rejects stops the block for good.

Top module: `nbl_rx_deframer`

## Requirements
- R1: In the framed mode (HEADERLESS=0), the first two characters after a descriptor must both be 9'h000. They are consumed as a header and cause no memory write.
- R2: Data bytes pair low byte first. Each pair is written as one word {high[7:0], low[7:0]}. The first word goes to the descriptor address and each later word to the previous address plus 2.
- R3: In the framed mode, a character with bit 8 set ends the message. Its low eight bits are still stored as data.
- R4: In the headerless mode (HEADERLESS=1), there is no header. The byte 8'h04 ends the message and is stored as data, and bit 8 has no effect.
- R5: Once a write uses up the descriptor's word count, the message ends even without an end marker.
- R6: One cycle after the write that ends a message, done is high for exactly one cycle. At that point done_len equals the loaded word count minus the words still unused.
- R7: If the message ends on a low byte, the word {8'h00, low} is still written and counted in done_len, and done_odd is 1. Otherwise done_odd is 0.
- R8: If mem_err is high during a write, halted becomes 1 and stays 1 until reset. After that, no further writes and no done pulse occur.
- R9: In the framed mode, if the header characters are not both zero, input is discarded until two consecutive zero characters arrive.
- R10: After reset, busy, halted, done and mem_we are 0. A descriptor is accepted only while busy is 0, and characters arriving while busy is 0 cause no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Load a descriptor (taken when busy is 0) |
| desc_addr | input | ADDR_W | Start byte address of the buffer |
| desc_words | input | CNT_W | Buffer capacity in words, at least 1 |
| busy | output | 1 | A descriptor is loaded and not yet finished |
| ch_valid | input | 1 | A character is present this cycle |
| ch_data | input | 9 | Received character, bit 8 is the ninth bit |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Write byte address |
| mem_wdata | output | 16 | Write data word |
| mem_err | input | 1 | Memory rejects the write in this cycle |
| done | output | 1 | One-cycle completion pulse |
| done_len | output | CNT_W | Words written in the finished message |
| done_odd | output | 1 | The last word held a single byte |
| halted | output | 1 | Stopped after a rejected write |

## Verification
If the header tracking goes wrong, a spurious write appears on the very character that should have been dropped. A low/high phase slip shows up within one word as swapped bytes, or as a partial word with a zero high byte where a full word was due. Errors in the word counter or address stepping show up on the next write address, or on done_len in the cycle after the final character. A bad halt state shows up as a write or done pulse after a rejected write.

// File: rtl/nbl_rx_deframer.sv
module nbl_rx_deframer #(
  parameter bit HEADERLESS = 1'b0,
  parameter int ADDR_W = 18,
  parameter int CNT_W = 16,
  parameter logic [7:0] EOT_CHAR = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [CNT_W-1:0]  desc_words,
  output logic              busy,
  input  logic              ch_valid,
  input  logic [8:0]        ch_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic              mem_err,
  output logic              done,
  output logic [CNT_W-1:0]  done_len,
  output logic              done_odd,
  output logic              halted
);

  typedef enum logic [2:0] {S_IDLE, S_H1, S_H2, S_LO, S_HI, S_HALT} st_t;

  st_t               st;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  left, orig;
  logic [7:0]        lo;

  wire is_end  = HEADERLESS ? (ch_data[7:0] == EOT_CHAR) : ch_data[8];
  wire last_wd = (left == CNT_W'(1));
  wire finish  = mem_we && !mem_err && (is_end || last_wd);

  assign busy      = (st != S_IDLE);
  assign halted    = (st == S_HALT);
  assign mem_we    = ch_valid && ((st == S_LO && is_end) || st == S_HI);
  assign mem_addr  = addr;
  assign mem_wdata = (st == S_HI) ? {ch_data[7:0], lo} : {8'h00, ch_data[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr     <= '0;
      left     <= '0;
      orig     <= '0;
      lo       <= '0;
      done     <= 1'b0;
      done_len <= '0;
      done_odd <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (desc_valid) begin
            addr <= desc_addr;
            left <= desc_words;
            orig <= desc_words;
            st   <= HEADERLESS ? S_LO : S_H1;
          end
        S_H1:
          if (ch_valid && ch_data == 9'h000) st <= S_H2;
        S_H2:
          if (ch_valid) st <= (ch_data == 9'h000) ? S_LO : S_H1;
        S_LO, S_HI:
          if (mem_we && mem_err) begin
            st <= S_HALT;
          end else if (mem_we) begin
            left <= left - CNT_W'(1);
            addr <= addr + ADDR_W'(2);
            if (finish) begin
              st       <= S_IDLE;
              done     <= 1'b1;
              done_len <= orig - left + CNT_W'(1);
              done_odd <= (st == S_LO);
            end else begin
              st <= S_LO;
            end
          end else if (ch_valid) begin
            lo <= ch_data[7:0];
            st <= S_HI;
          end
        default: st <= S_HALT;
      endcase
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_err) |=> (mem_addr == $past(mem_addr) + ADDR_W'(2))); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_len != '0 && done_len <= orig)); // R5
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_err) |=> halted); // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_we && !done)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we); // R10

endmodule

// File: tb/nbl_rx_deframer_test.sv
module nbl_rx_deframer_test;
  localparam int AW = 18;
  localparam int CW = 16;

  typedef struct { int addr; int data; string req; } wr_t;
  typedef struct { int len; int odd; string req; } dn_t;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic          f_dv = 0, h_dv = 0, f_cv = 0, h_cv = 0, f_err = 0, h_err = 0;
  logic [AW-1:0] f_da = '0, h_da = '0;
  logic [CW-1:0] f_dw = '0, h_dw = '0;
  logic [8:0]    f_ch = '0, h_ch = '0;
  logic          f_busy, h_busy, f_we, h_we, f_done, h_done, f_odd, h_odd, f_halt, h_halt;
  logic [AW-1:0] f_ma, h_ma;
  logic [15:0]   f_wd, h_wd;
  logic [CW-1:0] f_len, h_len;

  nbl_rx_deframer #(.HEADERLESS(1'b0), .ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .desc_valid(f_dv), .desc_addr(f_da), .desc_words(f_dw),
    .busy(f_busy), .ch_valid(f_cv), .ch_data(f_ch), .mem_we(f_we), .mem_addr(f_ma),
    .mem_wdata(f_wd), .mem_err(f_err), .done(f_done), .done_len(f_len),
    .done_odd(f_odd), .halted(f_halt));

  nbl_rx_deframer #(.HEADERLESS(1'b1), .ADDR_W(AW), .CNT_W(CW)) uut_hl (
    .clk(clk), .rst_n(rst_n), .desc_valid(h_dv), .desc_addr(h_da), .desc_words(h_dw),
    .busy(h_busy), .ch_valid(h_cv), .ch_data(h_ch), .mem_we(h_we), .mem_addr(h_ma),
    .mem_wdata(h_wd), .mem_err(h_err), .done(h_done), .done_len(h_len),
    .done_odd(h_odd), .halted(h_halt));

  int total = 0, failed = 0;
  bit ended = 0;
  wr_t f_wq[$], h_wq[$];
  dn_t f_dq[$], h_dq[$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  task automatic mon_wr(input logic we, input logic [AW-1:0] a, input logic [15:0] d, ref wr_t q[$]);
    wr_t e;
    if (we) begin
      if (q.size() == 0) check(0, "R10", "unexpected write addr", int'(a), -1);
      else begin
        e = q.pop_front();
        check(int'(a) == e.addr, e.req, "write addr", int'(a), e.addr);
        check(int'(d) == e.data, e.req, "write data", int'(d), e.data);
      end
    end
  endtask

  task automatic mon_dn(input logic dn, input logic [CW-1:0] l, input logic o, ref dn_t q[$]);
    dn_t e;
    if (dn) begin
      if (q.size() == 0) check(0, "R8", "unexpected done len", int'(l), -1);
      else begin
        e = q.pop_front();
        check(int'(l) == e.len, e.req, "done_len", int'(l), e.len);
        check(int'(o) == e.odd, e.req, "done_odd", int'(o), e.odd);
      end
    end
  endtask

  initial forever begin
    @(negedge clk); #3;
    if (rst_n) begin
      mon_wr(f_we, f_ma, f_wd, f_wq);
      mon_wr(h_we, h_ma, h_wd, h_wq);
      mon_dn(f_done, f_len, f_odd, f_dq);
      mon_dn(h_done, h_len, h_odd, h_dq);
    end
  end

  task automatic start(input bit hl, input int a, input int w);
    @(negedge clk);
    if (hl) begin h_dv = 1; h_da = AW'(a); h_dw = CW'(w); end
    else begin f_dv = 1; f_da = AW'(a); f_dw = CW'(w); end
    @(negedge clk);
    f_dv = 0; h_dv = 0;
  endtask

  task automatic send(input bit hl, input logic [8:0] c);
    @(negedge clk);
    if (hl) begin h_cv = 1; h_ch = c; end
    else begin f_cv = 1; f_ch = c; end
  endtask

  task automatic quiet();
    @(negedge clk);
    f_cv = 0; h_cv = 0; f_err = 0;
  endtask

  function automatic void ew(input bit hl, input int a, input int d, input string r);
    wr_t e = '{a, d, r};
    if (hl) h_wq.push_back(e); else f_wq.push_back(e);
  endfunction

  function automatic void ed(input bit hl, input int l, input int o, input string r);
    dn_t e = '{l, o, r};
    if (hl) h_dq.push_back(e); else f_dq.push_back(e);
  endfunction

  task automatic drain(input string r);
    repeat (3) @(negedge clk);
    check(f_wq.size() + h_wq.size() == 0, r, "writes missing", f_wq.size() + h_wq.size(), 0);
    check(f_dq.size() + h_dq.size() == 0, r, "done missing", f_dq.size() + h_dq.size(), 0);
  endtask

  initial begin
    #1_000_000;
    check(0, "R6", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    check(f_busy == 0 && f_halt == 0, "R10", "reset busy/halted", {f_busy, f_halt}, 0);
    check(f_we == 0 && f_done == 0, "R10", "reset we/done", {f_we, f_done}, 0);
    rst_n = 1;

    // R10: characters with no descriptor are ignored
    send(0, 9'h011); send(0, 9'h122); send(1, 9'h004); quiet();
    #3 check(f_busy == 0 && h_busy == 0, "R10", "busy after idle chars", {f_busy, h_busy}, 0);
    drain("R10");

    // R1 R2 R3: header, two full words, ninth bit on a high byte
    start(0, 'h1000, 4);
    send(0, 9'h000); send(0, 9'h000);
    ew(0, 'h1000, 'h2211, "R2"); send(0, 9'h011); send(0, 9'h022);
    ew(0, 'h1002, 'h4433, "R3"); ed(0, 2, 0, "R6"); send(0, 9'h033); send(0, 9'h144);
    quiet(); drain("R1");

    // R7: ends on a low byte
    start(0, 'h2000, 5);
    send(0, 9'h000); send(0, 9'h000);
    ew(0, 'h2000, 'hBBAA, "R2"); send(0, 9'h0AA); send(0, 9'h0BB);
    ew(0, 'h2002, 'h00CC, "R7"); ed(0, 2, 1, "R7"); send(0, 9'h1CC);
    quiet(); drain("R7");

    // R9: bad header characters are discarded
    start(0, 'h3000, 3);
    send(0, 9'h005); send(0, 9'h000); send(0, 9'h007); send(0, 9'h000); send(0, 9'h000);
    ew(0, 'h3000, 'h0201, "R9"); ed(0, 1, 0, "R9"); send(0, 9'h001); send(0, 9'h102);
    quiet(); drain("R9");

    // R5: word count exhausted, address crosses a 16-bit boundary
    start(0, 'h2FFFE, 2);
    send(0, 9'h000); send(0, 9'h000);
    ew(0, 'h2FFFE, 'h0201, "R2"); send(0, 9'h001); send(0, 9'h002);
    ew(0, 'h30000, 'h0403, "R5"); ed(0, 2, 0, "R5"); send(0, 9'h003); send(0, 9'h004);
    send(0, 9'h005); send(0, 9'h006);
    quiet();
    #3 check(f_busy == 0, "R5", "busy after count exhausted", f_busy, 0);
    drain("R5");

    // R4: headerless, EOT on a high byte, bit 8 ignored
    start(1, 'h0100, 8);
    ew(1, 'h0100, 'h4241, "R4"); send(1, 9'h041); send(1, 9'h142);
    ew(1, 'h0102, 'h0443, "R4"); ed(1, 2, 0, "R4"); send(1, 9'h043); send(1, 9'h004);
    quiet(); drain("R4");

    // R4 R7: headerless, EOT on a low byte
    start(1, 'h0300, 8);
    ew(1, 'h0300, 'h6261, "R4"); send(1, 9'h061); send(1, 9'h062);
    ew(1, 'h0302, 'h0004, "R7"); ed(1, 2, 1, "R7"); send(1, 9'h004);
    quiet(); drain("R7");

    // R8: rejected write halts the framed instance
    start(0, 'h5000, 4);
    send(0, 9'h000); send(0, 9'h000);
    send(0, 9'h010);
    ew(0, 'h5000, 'h2010, "R8"); send(0, 9'h020); f_err = 1;
    quiet();
    #3 check(f_halt == 1, "R8", "halted after error", f_halt, 1);
    send(0, 9'h030); send(0, 9'h140); send(0, 9'h050); send(0, 9'h160);
    quiet();
    start(0, 'h6000, 2);
    send(0, 9'h000); send(0, 9'h000); send(0, 9'h101);
    quiet();
    #3 check(f_halt == 1 && f_busy == 1, "R8", "still halted", {f_halt, f_busy}, 3);
    drain("R8");

    finish_up();
  end
endmodule